// File: doc/BRIEF.md
# Ethernet Port Status LED Driver

This block turns the status of a 10/100 Ethernet port into three active-high LED-on outputs: a link indicator, a speed indicator and an activity indicator. It takes link state, line speed, duplex, transmit and receive activity and collision. It makes its own timing from a prescaled system clock, so that short activity bursts become a visible lamp and sustained traffic makes the link lamp flash.

The link and activity lamps have three display modes. In the first, the link lamp shows link state and the activity lamp shows traffic. In the second, the link lamp flashes with traffic and the activity lamp shows collisions. In the third, the link lamp flashes with traffic and the activity lamp shows full duplex. After reset, a strap input sampled during reset selects the first or second mode. An override input from a register can select any of the three modes, and it is the only route to the third mode. Each lamp has a disable bit, so its pin can be handed over to general-purpose use. A disabled lamp stays dark.

Top module: `led_status_drv`

## Requirements
- R1: When the effective mode is mode 1, `led_link` is on exactly when `link_up` was high at the previous clock edge, with no flashing, even during activity.
- R2: In modes 2 and 3, `led_link` is off while `link_up` is low. With the link up and no activity, it is steadily on. While activity, including its stretched tail, persists, it toggles every `BLINK_TICKS` prescaler ticks.
- R3: `led_speed` follows `speed_100` (1 = 100 Mb/s, 0 = 10 Mb/s) in every mode.
- R4: In mode 1, `led_act` is on while `tx_act` or `rx_act` is high and during the stretch time after them.
- R5: `led_act` shows `collision` in mode 2 and `full_duplex` in mode 3.
- R6: Mode selection works as follows. When `mode_ovr_en` is 0, the mode comes from `strap_mode2` as sampled while `rst` is high: 0 selects mode 1 and 1 selects mode 2. When `mode_ovr_en` is 1, `mode_ovr` selects the mode: 2'b01 gives mode 1, 2'b10 gives mode 2, 2'b11 gives mode 3, and 2'b00 gives mode 1.
- R7: After activity ends, the mode-1 activity lamp stays lit for at least `(STRETCH_TICKS-1)*TICK_DIV` and at most `STRETCH_TICKS*TICK_DIV+2` clock cycles. Each new activity cycle reloads the stretch time.
- R8: The bits of `gpio_dis` force a lamp off. Bit 0 controls the link lamp, bit 1 the speed lamp and bit 2 the activity lamp.
- R9: All three lamps are registered. They show the inputs sampled at the previous edge, and they are all off during and right after reset.
- R10: Changes on `strap_mode2` after reset has been released have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| strap_mode2 | input | 1 | Power-up mode strap: 0 = mode 1, 1 = mode 2 |
| mode_ovr_en | input | 1 | Register override enable for the display mode |
| mode_ovr | input | 2 | Register override mode code |
| link_up | input | 1 | Link is good |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Full-duplex operation |
| tx_act | input | 1 | Transmit activity |
| rx_act | input | 1 | Receive activity |
| collision | input | 1 | Collision detected |
| gpio_dis | input | 3 | Per-lamp disable: [0] link, [1] speed, [2] activity |
| led_link | output | 1 | Link lamp on |
| led_speed | output | 1 | Speed lamp on |
| led_act | output | 1 | Activity lamp on |

## Verification
Every steady-state lamp value is due one clock edge after the inputs change, because one output register lies between the inputs and the lamps. The bench therefore records each expected triple with a due cycle one edge ahead and compares it at the falling edge after that. Time-based results, such as the stretch tail and the flash rate, depend on where the free-running prescaler happens to be. For these the bench counts lit cycles, or lamp toggles, over a window and checks them against bounds that cover the one-tick uncertainty. Before any steady check that involves the activity lamp, the bench waits until any stretch tail has run out.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef enum logic [1:0] {
        LM_LINK   = 2'b01,
        LM_COLL   = 2'b10,
        LM_DUPLEX = 2'b11
    } led_mode_e;

    typedef struct packed {
        logic link_up;
        logic speed_100;
        logic full_duplex;
        logic collision;
    } port_status_t;

    typedef struct packed {
        logic link;
        logic speed;
        logic act;
    } led_vec_t;

    localparam int DIS_LINK  = 0;
    localparam int DIS_SPEED = 1;
    localparam int DIS_ACT   = 2;

    function automatic led_mode_e decode_ovr(input logic [1:0] code);
        led_mode_e m;
        case (code)
            2'b10:   m = LM_COLL;
            2'b11:   m = LM_DUPLEX;
            default: m = LM_LINK;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] pcnt;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt   <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= (pcnt == LAST);
            pcnt   <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
        end
    end

    assign tick = tick_q;

    generate
        if (TICK_DIV > 1) begin : g_chk
            p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
    parameter int STRETCH_TICKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic act_raw,
    output logic act_busy
);
    localparam int SW = $clog2(STRETCH_TICKS + 1);
    localparam logic [SW-1:0] RELOAD = SW'(STRETCH_TICKS);

    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (act_raw) begin
            cnt <= RELOAD;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign act_busy = act_raw || (cnt != '0);

    p_stretch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!act_raw && !tick && cnt != '0) |=> (act_busy || act_raw));

    p_stretch_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !act_raw) |=> (cnt == '0));
endmodule

// File: rtl/led_blinker.sv
module led_blinker #(
    parameter int BLINK_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic busy,
    output logic phase
);
    localparam int BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [BW-1:0] LAST = BW'(BLINK_TICKS - 1);

    logic [BW-1:0] tcnt;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt    <= '0;
            phase_q <= 1'b1;
        end else if (!busy) begin
            tcnt    <= '0;
            phase_q <= 1'b1;
        end else if (tick) begin
            if (tcnt == LAST) begin
                tcnt    <= '0;
                phase_q <= ~phase_q;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign phase = phase_q;

    p_idle_lit_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> phase);

    p_flip_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(phase));
endmodule

// File: rtl/led_mode_sel.sv
module led_mode_sel
    import led_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strap_mode2,
    input  logic      ovr_en,
    input  logic [1:0] ovr_code,
    output led_mode_e mode
);
    logic strap_q;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_mode2;
    end

    always_comb begin
        if (ovr_en)       mode = decode_ovr(ovr_code);
        else if (strap_q) mode = LM_COLL;
        else              mode = LM_LINK;
    end

    p_strap_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_q));

    p_no_duplex_from_strap_r6: assert property (@(posedge clk) disable iff (rst)
        !ovr_en |-> (mode != LM_DUPLEX));
endmodule

// File: rtl/led_out_map.sv
module led_out_map
    import led_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  led_mode_e    mode,
    input  port_status_t st,
    input  logic         act_busy,
    input  logic         phase,
    input  logic [2:0]   dis,
    output led_vec_t     leds
);
    led_vec_t nxt, q;

    always_comb begin
        nxt.speed = st.speed_100;
        case (mode)
            LM_COLL: begin
                nxt.link = st.link_up && (!act_busy || phase);
                nxt.act  = st.collision;
            end
            LM_DUPLEX: begin
                nxt.link = st.link_up && (!act_busy || phase);
                nxt.act  = st.full_duplex;
            end
            default: begin
                nxt.link = st.link_up;
                nxt.act  = act_busy;
            end
        endcase
        if (dis[DIS_LINK])  nxt.link  = 1'b0;
        if (dis[DIS_SPEED]) nxt.speed = 1'b0;
        if (dis[DIS_ACT])   nxt.act   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign leds = q;

    p_link_down_dark_r2: assert property (@(posedge clk) disable iff (rst)
        !st.link_up |=> !leds.link);

    p_mode1_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_LINK && st.link_up && !dis[DIS_LINK]) |=> leds.link);

    p_speed_dis_r8: assert property (@(posedge clk) disable iff (rst)
        dis[DIS_SPEED] |=> !leds.speed);

    p_act_dis_r8: assert property (@(posedge clk) disable iff (rst)
        dis[DIS_ACT] |=> !leds.act);
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
    import led_pkg::*;
#(
    parameter int TICK_DIV      = 50000,
    parameter int STRETCH_TICKS = 50,
    parameter int BLINK_TICKS   = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_mode2,
    input  logic       mode_ovr_en,
    input  logic [1:0] mode_ovr,
    input  logic       link_up,
    input  logic       speed_100,
    input  logic       full_duplex,
    input  logic       tx_act,
    input  logic       rx_act,
    input  logic       collision,
    input  logic [2:0] gpio_dis,
    output logic       led_link,
    output logic       led_speed,
    output logic       led_act
);
    logic         tick;
    logic         act_busy;
    logic         phase;
    led_mode_e    mode;
    port_status_t st;
    led_vec_t     leds;

    assign st = '{link_up: link_up, speed_100: speed_100,
                  full_duplex: full_duplex, collision: collision};

    led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    led_act_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_stretch (
        .clk(clk), .rst(rst), .tick(tick),
        .act_raw(tx_act | rx_act), .act_busy(act_busy)
    );

    led_blinker #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
        .clk(clk), .rst(rst), .tick(tick), .busy(act_busy), .phase(phase)
    );

    led_mode_sel u_mode (
        .clk(clk), .rst(rst), .strap_mode2(strap_mode2),
        .ovr_en(mode_ovr_en), .ovr_code(mode_ovr), .mode(mode)
    );

    led_out_map u_map (
        .clk(clk), .rst(rst), .mode(mode), .st(st),
        .act_busy(act_busy), .phase(phase), .dis(gpio_dis), .leds(leds)
    );

    assign led_link  = leds.link;
    assign led_speed = leds.speed;
    assign led_act   = leds.act;

    p_reset_dark_r9: assert property (@(posedge clk)
        rst |=> (!led_link && !led_speed && !led_act));

    p_speed_tracks_r3: assert property (@(posedge clk) disable iff (rst)
        (speed_100 && !gpio_dis[1]) |=> led_speed);
endmodule

// File: tb/tb_led_status_drv.sv
module tb_led_status_drv;
    localparam int DIV = 4;
    localparam int STR = 3;
    localparam int BLK = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap_mode2 = 1'b0, mode_ovr_en = 1'b0;
    logic [1:0] mode_ovr = 2'b00;
    logic link_up = 0, speed_100 = 0, full_duplex = 0;
    logic tx_act = 0, rx_act = 0, collision = 0;
    logic [2:0] gpio_dis = 3'b000;
    logic led_link, led_speed, led_act;

    always #10 clk = ~clk;

    led_status_drv #(.TICK_DIV(DIV), .STRETCH_TICKS(STR), .BLINK_TICKS(BLK)) dut (
        .clk(clk), .rst(rst), .strap_mode2(strap_mode2),
        .mode_ovr_en(mode_ovr_en), .mode_ovr(mode_ovr),
        .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
        .tx_act(tx_act), .rx_act(rx_act), .collision(collision),
        .gpio_dis(gpio_dis),
        .led_link(led_link), .led_speed(led_speed), .led_act(led_act)
    );

    typedef struct {
        int    due;
        logic  [2:0] exp;
        string tag;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare {link,speed,act} once an item is due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            n_cmp++;
            if ({led_link, led_speed, led_act} !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", it.tag,
                         {led_link, led_speed, led_act}, it.exp);
            end
        end
    end

    task automatic expect_next(input logic [2:0] e, input string tag);
        item_t it;
        it.due = cyc + 1;
        it.exp = e;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        strap_mode2 = strap;
        idle(3);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        #200000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lit, toggles;
        logic prev;
        idle(1);
        // R9: dark during reset
        check({led_link, led_speed, led_act} == 3'b000, "R9 reset", led_link, 0);
        do_reset(1'b0);
        expect_next(3'b000, "R9 after reset");

        // R1/R3 in strap mode 1
        link_up = 1; speed_100 = 1;
        expect_next(3'b110, "R1 R3 link+100");
        speed_100 = 0;
        expect_next(3'b100, "R3 10Mb");
        link_up = 0;
        expect_next(3'b000, "R1 link down");
        link_up = 1; speed_100 = 1;
        expect_next(3'b110, "R1 link up again");

        // R4: activity lamp in mode 1, link lamp steady (R1)
        rx_act = 1;
        expect_next(3'b111, "R4 rx activity");
        rx_act = 0; tx_act = 1;
        lit = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (led_link && led_act) lit++;
        end
        check(lit == 40, "R1 steady under activity", lit, 40);

        // R7: stretch tail length
        tx_act = 0;
        lit = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (led_act && lit == i) lit++;
        end
        check(lit >= (STR-1)*DIV && lit <= STR*DIV + 2, "R7 stretch length", lit, STR*DIV);
        check(led_act == 1'b0, "R7 lamp ends", led_act, 0);

        // R8: disables
        gpio_dis = 3'b001;
        expect_next(3'b010, "R8 link disabled");
        gpio_dis = 3'b010;
        expect_next(3'b100, "R8 speed disabled");
        gpio_dis = 3'b100; tx_act = 1;
        expect_next(3'b110, "R8 act disabled");
        tx_act = 0; gpio_dis = 3'b000;
        idle(20);

        // R10: strap change after reset ignored (stay mode 1)
        strap_mode2 = 1; collision = 1;
        idle(2);
        expect_next(3'b110, "R10 strap ignored");
        collision = 0;

        // R5/R6: override modes
        mode_ovr_en = 1; mode_ovr = 2'b11; full_duplex = 1;
        expect_next(3'b111, "R5 mode3 duplex on");
        full_duplex = 0;
        expect_next(3'b110, "R5 mode3 duplex off");
        mode_ovr = 2'b10; collision = 1;
        expect_next(3'b111, "R5 mode2 collision");
        collision = 0; full_duplex = 1;
        expect_next(3'b110, "R5 mode2 ignores duplex");
        mode_ovr = 2'b00; collision = 1;
        expect_next(3'b110, "R6 code 00 is mode 1");
        mode_ovr = 2'b01;
        expect_next(3'b110, "R6 code 01 is mode 1");
        collision = 0; full_duplex = 0;

        // R2: flashing in mode 2
        mode_ovr = 2'b10;
        idle(2);
        rx_act = 1;
        toggles = 0;
        prev = led_link;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); #1;
            if (led_link !== prev) toggles++;
            prev = led_link;
        end
        check(toggles >= 8 && toggles <= 12, "R2 flash rate", toggles, 80/(DIV*BLK));
        rx_act = 0;
        idle(30);
        expect_next(3'b110, "R2 steady after activity");
        link_up = 0; rx_act = 1;
        lit = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (led_link) lit++;
        end
        check(lit == 0, "R2 dark when link down", lit, 0);
        rx_act = 0; link_up = 1;
        idle(30);

        // R6: strap selects mode 2 at reset
        mode_ovr_en = 0;
        do_reset(1'b1);
        strap_mode2 = 0; collision = 1;
        expect_next(3'b111, "R6 strap mode2 collision");
        collision = 0;
        expect_next(3'b110, "R6 strap mode2 no collision");

        idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule